// File: doc/BRIEF.md
# Wrapping Address Register Update Unit

This block holds the pointer state of a DSP address generator. There are four address registers, each with its own index register and wrap mask. A 2-bit selector picks a register, and the same selector value picks its index and mask. Each cycle the block takes up to two pointer-update commands, one on each of two command ports. A command can step its address register down by one, step it up by one, or add the paired index register as a signed value. The new value appears on the next clock edge.

The up and down steps are modulo steps set by the wrap mask. Stepping down from an address whose masked bits are all zero jumps to the top of the window. Stepping up from an address whose masked bits are all one jumps to the bottom of the window. A mask of all ones gives plain 16-bit wrap-around arithmetic. A load port writes any address, index or mask register. Flat read buses show all twelve registers at all times. The block does no memory access and keeps no program counter. It only computes and stores pointers.

Top module: `ptr_update_unit`

## Requirements
- R1: After a synchronous reset every address and index register reads 0x0000 and every wrap mask reads 0xFFFF.
- R2: When `ld_en` is high, the value on `ld_data` is written into the register picked by `ld_sel`. `ld_kind` chooses the register file: 0 for address, 1 for index, 2 for wrap mask. The new value is visible after the next clock edge.
- R3: A command port code selects the operation: 00 means no operation, 01 means step down, 10 means step up, 11 means add the index. The port's 2-bit select picks the address register, and the same value picks its index register and wrap mask.
- R4: For a step down, the new address is A | W when (A & W) == 0. Otherwise it is A - 1. Here A is the address register and W is its wrap mask.
- R5: For a step up, the new address is A & ~W when (A & W) == W. Otherwise it is A + 1.
- R6: For an index add, the new address is A plus the paired index register, read as a signed 16-bit value. The sum wraps modulo 2^16.
- R7: With a wrap mask of 0xFFFF, a step down or a step up gives A - 1 or A + 1 modulo 2^16. For example, 0x0000 steps down to 0xFFFF.
- R8: Two commands that name different registers in the same cycle both take effect on the same clock edge.
- R9: Two active commands that name the same register in the same cycle are illegal.
- R10: A load to an address register in the same cycle as a command to that register wins, and the command is dropped. A command to another register in that cycle still takes effect.
- R11: An address register that no command and no load addresses keeps its value.
- R12: A load with `ld_kind` equal to 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_a_op | input | 2 | Operation code for command port A |
| cmd_a_sel | input | 2 | Register select for command port A |
| cmd_b_op | input | 2 | Operation code for command port B |
| cmd_b_sel | input | 2 | Register select for command port B |
| ld_en | input | 1 | Load strobe |
| ld_kind | input | 2 | Target file for the load: 0 address, 1 index, 2 wrap mask, 3 none |
| ld_sel | input | 2 | Register number for the load |
| ld_data | input | 16 | Load value |
| ar_flat | output | 64 | All address registers; register n sits at bits 16n+15 down to 16n |
| ix_flat | output | 64 | All index registers, packed the same way |
| wp_flat | output | 64 | All wrap masks, packed the same way |

## Verification
Some properties are checked on every cycle:
- Two active commands never name the same register.
- An address register that nothing addresses keeps its value.
- The state is correct in the first cycle after reset.
- With a full mask, a step up or a step down is plain plus or minus one.

Other behaviour only the bench scenarios can show:
- The exact mask rules at each window boundary.
- Signed index addition that crosses zero.
- A load winning over a command on the same register.
- Concurrent commands on two registers.
- An ignored load kind.

// File: rtl/ptr_update_pkg.sv
package ptr_update_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_DEC  = 2'b01,
        OP_INC  = 2'b10,
        OP_IDX  = 2'b11
    } ptr_op_t;

    typedef enum logic [1:0] {
        LD_ADDR  = 2'd0,
        LD_INDEX = 2'd1,
        LD_MASK  = 2'd2,
        LD_NONE  = 2'd3
    } ld_kind_t;

endpackage

// File: rtl/ptr_cmd_route.sv
module ptr_cmd_route
    import ptr_update_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_op_t          a_op,
    input  logic [SEL_W-1:0] a_sel,
    input  ptr_op_t          b_op,
    input  logic [SEL_W-1:0] b_sel,
    output ptr_op_t          reg_op [NUM_REGS]
);

    // Port A takes the register when both ports name it; that case is illegal.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_route
        always_comb begin
            if (a_op != OP_NONE && a_sel == SEL_W'(i))
                reg_op[i] = a_op;
            else if (b_op != OP_NONE && b_sel == SEL_W'(i))
                reg_op[i] = b_op;
            else
                reg_op[i] = OP_NONE;
        end
    end

    // R9
    no_dual_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (a_op != OP_NONE && b_op != OP_NONE) |-> (a_sel != b_sel));

endmodule

// File: rtl/ptr_step.sv
module ptr_step
    import ptr_update_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  ptr_op_t           op,
    input  logic [DATA_W-1:0] ar,
    input  logic [DATA_W-1:0] ix,
    input  logic [DATA_W-1:0] wp,
    output logic [DATA_W-1:0] nxt
);

    logic at_bottom;
    logic at_top;

    assign at_bottom = ((ar & wp) == '0);
    assign at_top    = ((ar & wp) == wp);

    always_comb begin
        unique case (op)
            OP_DEC:  nxt = at_bottom ? (ar | wp) : (ar - DATA_W'(1));
            OP_INC:  nxt = at_top ? (ar & ~wp) : (ar + DATA_W'(1));
            // A two's complement add is the same as an unsigned add modulo 2^W.
            OP_IDX:  nxt = ar + ix;
            default: nxt = ar;
        endcase
    end

endmodule

// File: rtl/ptr_update_unit.sv
module ptr_update_unit
    import ptr_update_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int FLAT_W  = DATA_W * NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_a_op,
    input  logic [SEL_W-1:0]  cmd_a_sel,
    input  logic [1:0]        cmd_b_op,
    input  logic [SEL_W-1:0]  cmd_b_sel,
    input  logic              ld_en,
    input  logic [1:0]        ld_kind,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic [FLAT_W-1:0] ar_flat,
    output logic [FLAT_W-1:0] ix_flat,
    output logic [FLAT_W-1:0] wp_flat
);

    logic [DATA_W-1:0] ar_q  [NUM_REGS];
    logic [DATA_W-1:0] ix_q  [NUM_REGS];
    logic [DATA_W-1:0] wp_q  [NUM_REGS];
    logic [DATA_W-1:0] ar_nx [NUM_REGS];
    ptr_op_t           reg_op [NUM_REGS];

    ptr_cmd_route #(.NUM_REGS(NUM_REGS)) i_route (
        .clk    (clk),
        .rst    (rst),
        .a_op   (ptr_op_t'(cmd_a_op)),
        .a_sel  (cmd_a_sel),
        .b_op   (ptr_op_t'(cmd_b_op)),
        .b_sel  (cmd_b_sel),
        .reg_op (reg_op)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit_ar, hit_ix, hit_wp;

        assign hit_ar = ld_en && ld_kind == LD_ADDR  && ld_sel == SEL_W'(i);
        assign hit_ix = ld_en && ld_kind == LD_INDEX && ld_sel == SEL_W'(i);
        assign hit_wp = ld_en && ld_kind == LD_MASK  && ld_sel == SEL_W'(i);

        ptr_step #(.DATA_W(DATA_W)) i_step (
            .op  (reg_op[i]),
            .ar  (ar_q[i]),
            .ix  (ix_q[i]),
            .wp  (wp_q[i]),
            .nxt (ar_nx[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ar_q[i] <= '0;
                ix_q[i] <= '0;
                wp_q[i] <= '1;
            end else begin
                if (hit_ar)      ar_q[i] <= ld_data;
                else             ar_q[i] <= ar_nx[i];
                if (hit_ix)      ix_q[i] <= ld_data;
                if (hit_wp)      wp_q[i] <= ld_data;
            end
        end

        assign ar_flat[i*DATA_W +: DATA_W] = ar_q[i];
        assign ix_flat[i*DATA_W +: DATA_W] = ix_q[i];
        assign wp_flat[i*DATA_W +: DATA_W] = wp_q[i];

        // R11
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_op[i] == OP_NONE && !hit_ar) |=> $stable(ar_q[i]));

        // R1
        reset_state_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (ar_q[i] == '0 && ix_q[i] == '0 && wp_q[i] == '1));

        // R7
        full_mask_dec_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_op[i] == OP_DEC && wp_q[i] == '1 && !hit_ar)
            |=> ar_q[i] == $past(ar_q[i]) - DATA_W'(1));

        // R7
        full_mask_inc_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_op[i] == OP_INC && wp_q[i] == '1 && !hit_ar)
            |=> ar_q[i] == $past(ar_q[i]) + DATA_W'(1));
    end

endmodule

// File: tb/test_ptr_update_unit.sv
`timescale 1ns/1ps
module test_ptr_update_unit;

    localparam int W = 16;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_a_op = 2'b00, cmd_b_op = 2'b00;
    logic [1:0]    cmd_a_sel = 2'd0, cmd_b_sel = 2'd0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_kind = 2'd0;
    logic [1:0]    ld_sel = 2'd0;
    logic [W-1:0]  ld_data = '0;
    logic [N*W-1:0] ar_flat, ix_flat, wp_flat;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ptr_update_unit i_ptr_update_unit (
        .clk(clk), .rst(rst),
        .cmd_a_op(cmd_a_op), .cmd_a_sel(cmd_a_sel),
        .cmd_b_op(cmd_b_op), .cmd_b_sel(cmd_b_sel),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_sel(ld_sel), .ld_data(ld_data),
        .ar_flat(ar_flat), .ix_flat(ix_flat), .wp_flat(wp_flat)
    );

    typedef struct packed {
        logic [1:0]   op;
        logic [1:0]   sel;
        logic [W-1:0] ar;
        logic [W-1:0] ix;
        logic [W-1:0] wp;
        logic [W-1:0] expv;
    } vec_t;

    // op: 01 down, 10 up, 11 index add
    localparam vec_t VECS [10] = '{
        '{2'b01, 2'd0, 16'h0010, 16'h0000, 16'h000F, 16'h001F}, // R4 bottom wraps to top
        '{2'b01, 2'd1, 16'h0013, 16'h0000, 16'h000F, 16'h0012}, // R4 plain step
        '{2'b10, 2'd2, 16'h001F, 16'h0000, 16'h000F, 16'h0010}, // R5 top wraps to bottom
        '{2'b10, 2'd3, 16'h0015, 16'h0000, 16'h000F, 16'h0016}, // R5 plain step
        '{2'b11, 2'd0, 16'h0100, 16'hFFFE, 16'hFFFF, 16'h00FE}, // R6 negative index
        '{2'b11, 2'd1, 16'hFFFF, 16'h0003, 16'h00FF, 16'h0002}, // R6 carry wraps
        '{2'b01, 2'd2, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF}, // R7
        '{2'b10, 2'd3, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000}, // R7
        '{2'b01, 2'd1, 16'h1234, 16'h0000, 16'h0000, 16'h1234}, // R4 empty mask
        '{2'b10, 2'd3, 16'h00FF, 16'h0000, 16'h00FF, 16'h0000}  // R5 byte window
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [1:0] kind, input logic [1:0] sel, input logic [W-1:0] d);
        ld_en = 1'b1; ld_kind = kind; ld_sel = sel; ld_data = d;
        tick();
        ld_en = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] aop, input logic [1:0] asel,
                       input logic [1:0] bop, input logic [1:0] bsel);
        cmd_a_op = aop; cmd_a_sel = asel; cmd_b_op = bop; cmd_b_sel = bsel;
        tick();
        cmd_a_op = 2'b00; cmd_b_op = 2'b00;
    endtask

    function automatic logic [W-1:0] ar_of(input int s);
        return ar_flat[s*W +: W];
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [N*W-1:0] snap_ar, snap_ix, snap_wp;
        do_reset();

        // R1
        check("R1 ar", ar_flat[W-1:0] | ar_flat[2*W-1:W] | ar_flat[3*W-1:2*W] | ar_flat[4*W-1:3*W], '0);
        check("R1 ix", ix_flat[W-1:0] | ix_flat[2*W-1:W] | ix_flat[3*W-1:2*W] | ix_flat[4*W-1:3*W], '0);
        check("R1 wp", wp_flat[W-1:0] & wp_flat[2*W-1:W] & wp_flat[3*W-1:2*W] & wp_flat[4*W-1:3*W], 16'hFFFF);

        // R3 vector walk
        for (int k = 0; k < 10; k++) begin
            load(2'd0, VECS[k].sel, VECS[k].ar);
            load(2'd1, VECS[k].sel, VECS[k].ix);
            load(2'd2, VECS[k].sel, VECS[k].wp);
            // R2
            check("R2 load wp", wp_flat[VECS[k].sel*W +: W], VECS[k].wp);
            cmd(VECS[k].op, VECS[k].sel, 2'b00, 2'd0);
            check($sformatf("R3 vector %0d", k), ar_of(VECS[k].sel), VECS[k].expv);
        end

        do_reset();

        // R8: two registers in one cycle
        load(2'd0, 2'd1, 16'h0005);
        load(2'd0, 2'd2, 16'h0008);
        cmd(2'b01, 2'd1, 2'b10, 2'd2);
        check("R8 port A reg1", ar_of(1), 16'h0004);
        check("R8 port B reg2", ar_of(2), 16'h0009);

        // R10: load beats command on the same register
        load(2'd0, 2'd0, 16'h0050);
        ld_en = 1'b1; ld_kind = 2'd0; ld_sel = 2'd0; ld_data = 16'h0777;
        cmd(2'b10, 2'd0, 2'b10, 2'd3);
        ld_en = 1'b0;
        check("R10 load wins", ar_of(0), 16'h0777);
        check("R10 other port", ar_of(3), 16'h0001);

        // R12: kind 3 changes nothing
        snap_ar = ar_flat; snap_ix = ix_flat; snap_wp = wp_flat;
        load(2'd3, 2'd1, 16'hBEEF);
        check("R12 ar", (ar_flat == snap_ar) ? 16'd1 : 16'd0, 16'd1);
        check("R12 ix", (ix_flat == snap_ix) ? 16'd1 : 16'd0, 16'd1);
        check("R12 wp", (wp_flat == snap_wp) ? 16'd1 : 16'd0, 16'd1);

        // R11 and R3: a no-op command and a step on another register
        snap_ar = ar_flat;
        cmd(2'b00, 2'd1, 2'b01, 2'd2);
        check("R11 reg0 hold", ar_of(0), snap_ar[0 +: W]);
        check("R11 reg1 hold", ar_of(1), snap_ar[W +: W]);
        check("R11 reg3 hold", ar_of(3), snap_ar[3*W +: W]);
        check("R3 reg2 down", ar_of(2), 16'h0008);

        // R6: positive index on reg 3
        load(2'd1, 2'd3, 16'h0010);
        cmd(2'b11, 2'd3, 2'b00, 2'd0);
        check("R6 positive index", ar_of(3), 16'h0011);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule